// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This purely combinational block chooses the address of the next instruction fetch for a 32-bit load/store processor. It receives the address of the current instruction, the instruction word itself, the two register operands that a conditional branch compares, and a register value that serves as an indirect jump destination. From the major opcode and the function field it classifies the instruction into one of six flow kinds. These are straight-line, branch when equal, branch when unequal, region jump, region jump with link, and register-indirect jump.

The block drives the chosen fetch address and a redirect flag. For the linking jump it also presents a write request for the return-address register. That request carries the register index and the address of the following instruction. An indirect destination whose two low bits are not zero is still used as given, and the block raises a separate misalignment indication so that a later stage can act on it. Delay slots, hazards and exceptions are handled elsewhere.

Top module: `npc_unit`

## Requirements
- R1: Any instruction that is not a taken branch and not a jump yields pc_next = pc_cur + 4 with redirect low. This covers every major opcode other than 2, 3, 4 and 5. It also covers opcode 0 whose function field (bits 5..0) is anything but 8.
- R2: Major opcode 4 (bits 31..26) is the branch-when-equal kind. When opnd_a equals opnd_b it is taken and gives pc_next = pc_cur + 4 + 4 * sign-extended bits 15..0, with redirect high, even when that sum equals pc_cur + 4.
- R3: Major opcode 5 is the branch-when-unequal kind. It is taken when opnd_a differs from opnd_b, and its target uses the same arithmetic as R2.
- R4: A branch whose condition fails gives pc_next = pc_cur + 4 with redirect low.
- R5: Major opcode 2 gives pc_next = {pc_cur[31:28], instr[25:0], 2'b00} with redirect high.
- R6: Major opcode 3 jumps to the same target as R5. It also raises link_we, presents link_reg = 31, and presents link_data = pc_cur + 4. No other instruction raises link_we.
- R7: Opcode 0 with function field 8 gives pc_next = jr_src with redirect high.
- R8: For the R7 instruction, jr_misaligned is high exactly when jr_src[1:0] is not 0, and pc_next still equals jr_src unchanged. For every other instruction jr_misaligned is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_cur | input | 32 | Address of the current instruction |
| instr | input | 32 | Current instruction word |
| opnd_a | input | 32 | First compared register value |
| opnd_b | input | 32 | Second compared register value |
| jr_src | input | 32 | Register value used as indirect destination |
| pc_next | output | 32 | Selected next fetch address |
| redirect | output | 1 | High when flow leaves the straight-line path |
| link_we | output | 1 | Return-address write request |
| link_reg | output | 5 | Index of the return-address register |
| link_data | output | 32 | Return address to write |
| jr_misaligned | output | 1 | Indirect destination not word aligned |

## Verification
The bench crosses several current addresses with a set of branch offsets. The addresses include ones near zero and ones at the top of memory. The offsets include zero, plus and minus one word, and both extremes of the 16-bit range. This separates scaling by four and adding to pc_cur + 4 from adding to pc_cur, and it shows that the sign is extended rather than zero-filled, including wrap-around. Each case is run with equal and unequal operands under both branch opcodes, so a swapped condition or an inverted sense shows up. Every major opcode and, under opcode 0, every function code is swept so that stray decodes are caught. Region jumps use addresses in different 256 MiB regions, which proves that the upper four bits come from the current address. Indirect destinations with each of the four low-bit patterns check both the pass-through and the misalignment flag.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int XLEN      = 32;
  localparam int OP_W      = 6;
  localparam int FUNCT_W   = 6;
  localparam int IMM_W     = 16;
  localparam int JIDX_W    = 26;
  localparam int REGION_W  = XLEN - JIDX_W - 2;
  localparam int INSN_BYTES = 4;

  typedef logic [XLEN-1:0] addr_t;

  localparam logic [OP_W-1:0]    OPC_SPECIAL = 6'd0;
  localparam logic [OP_W-1:0]    OPC_JUMP    = 6'd2;
  localparam logic [OP_W-1:0]    OPC_JLINK   = 6'd3;
  localparam logic [OP_W-1:0]    OPC_BREQ    = 6'd4;
  localparam logic [OP_W-1:0]    OPC_BRNE    = 6'd5;
  localparam logic [FUNCT_W-1:0] FN_JREG     = 6'd8;

  typedef enum logic [2:0] {
    FLOW_SEQ,
    FLOW_BEQ,
    FLOW_BNE,
    FLOW_JMP,
    FLOW_JAL,
    FLOW_JR
  } flow_e;

  function automatic flow_e classify(input logic [OP_W-1:0] op,
                                     input logic [FUNCT_W-1:0] fn);
    flow_e k;
    unique case (op)
      OPC_BREQ:    k = FLOW_BEQ;
      OPC_BRNE:    k = FLOW_BNE;
      OPC_JUMP:    k = FLOW_JMP;
      OPC_JLINK:   k = FLOW_JAL;
      OPC_SPECIAL: k = (fn == FN_JREG) ? FLOW_JR : FLOW_SEQ;
      default:     k = FLOW_SEQ;
    endcase
    return k;
  endfunction

  function automatic addr_t step_addr(input addr_t pc);
    return pc + addr_t'(INSN_BYTES);
  endfunction

  function automatic addr_t rel_target(input addr_t seq,
                                       input logic [IMM_W-1:0] imm);
    addr_t wide;
    wide = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
    return seq + (wide << 2);
  endfunction

  function automatic addr_t region_target(input addr_t pc,
                                          input logic [JIDX_W-1:0] idx);
    return {pc[XLEN-1 -: REGION_W], idx, 2'b00};
  endfunction
endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [XLEN-1:0]   insn,
  output flow_e             kind,
  output logic [IMM_W-1:0]  imm,
  output logic [JIDX_W-1:0] jidx
);
  logic [OP_W-1:0]    op_f;
  logic [FUNCT_W-1:0] fn_f;

  assign op_f = insn[XLEN-1 -: OP_W];
  assign fn_f = insn[FUNCT_W-1:0];
  assign imm  = insn[IMM_W-1:0];
  assign jidx = insn[JIDX_W-1:0];
  assign kind = classify(op_f, fn_f);

  always_comb begin
    if (op_f != OPC_SPECIAL && op_f != OPC_JUMP && op_f != OPC_JLINK &&
        op_f != OPC_BREQ && op_f != OPC_BRNE)
      p_other_op_seq_r1: assert (kind == FLOW_SEQ)
        else $error("unused opcode decoded as flow change");
  end
endmodule

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
(
  input  flow_e           kind,
  input  logic [XLEN-1:0] lhs,
  input  logic [XLEN-1:0] rhs,
  output logic            same,
  output logic            br_take
);
  assign same = (lhs == rhs);

  always_comb begin
    unique case (kind)
      FLOW_BEQ: br_take = same;
      FLOW_BNE: br_take = !same;
      default:  br_take = 1'b0;
    endcase
  end

  always_comb begin
    if (kind == FLOW_BEQ && br_take)
      p_beq_equal_r2: assert (lhs == rhs) else $error("beq taken on unequal");
    if (kind == FLOW_BNE && br_take)
      p_bne_differ_r3: assert (lhs != rhs) else $error("bne taken on equal");
  end
endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
(
  input  logic [XLEN-1:0]   pc,
  input  logic [IMM_W-1:0]  imm,
  input  logic [JIDX_W-1:0] jidx,
  output logic [XLEN-1:0]   seq_pc,
  output logic [XLEN-1:0]   br_pc,
  output logic [XLEN-1:0]   jmp_pc
);
  assign seq_pc = step_addr(pc);
  assign br_pc  = rel_target(seq_pc, imm);
  assign jmp_pc = region_target(pc, jidx);

  always_comb begin
    p_region_kept_r5: assert (jmp_pc[XLEN-1 -: REGION_W] == pc[XLEN-1 -: REGION_W]
                              && jmp_pc[1:0] == 2'b00)
      else $error("region jump target lost upper bits");
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int REG_IDX_W = 5,
  parameter int RA_INDEX  = 31
) (
  input  logic [31:0]          pc_cur,
  input  logic [31:0]          instr,
  input  logic [31:0]          opnd_a,
  input  logic [31:0]          opnd_b,
  input  logic [31:0]          jr_src,
  output logic [31:0]          pc_next,
  output logic                 redirect,
  output logic                 link_we,
  output logic [REG_IDX_W-1:0] link_reg,
  output logic [31:0]          link_data,
  output logic                 jr_misaligned
);
  flow_e             kind;
  logic [IMM_W-1:0]  imm;
  logic [JIDX_W-1:0] jidx;
  logic              ops_same;
  logic              br_take;
  logic [XLEN-1:0]   seq_pc;
  logic [XLEN-1:0]   br_pc;
  logic [XLEN-1:0]   jmp_pc;
  logic              is_jump;

  npc_decode u_dec (
    .insn(instr), .kind(kind), .imm(imm), .jidx(jidx)
  );

  npc_cond u_cond (
    .kind(kind), .lhs(opnd_a), .rhs(opnd_b), .same(ops_same), .br_take(br_take)
  );

  npc_target u_tgt (
    .pc(pc_cur), .imm(imm), .jidx(jidx),
    .seq_pc(seq_pc), .br_pc(br_pc), .jmp_pc(jmp_pc)
  );

  assign is_jump = (kind == FLOW_JMP) || (kind == FLOW_JAL) || (kind == FLOW_JR);

  always_comb begin
    unique case (kind)
      FLOW_BEQ, FLOW_BNE: pc_next = br_take ? br_pc : seq_pc;
      FLOW_JMP, FLOW_JAL: pc_next = jmp_pc;
      FLOW_JR:            pc_next = jr_src;
      default:            pc_next = seq_pc;
    endcase
  end

  assign redirect      = br_take || is_jump;
  assign link_we       = (kind == FLOW_JAL);
  assign link_reg      = REG_IDX_W'(RA_INDEX);
  assign link_data     = seq_pc;
  assign jr_misaligned = (kind == FLOW_JR) && (jr_src[1:0] != 2'b00);

  always_comb begin
    if (!redirect)
      p_seq_step_r1: assert (pc_next == pc_cur + 32'd4)
        else $error("straight-line address wrong");
    if (link_we)
      p_link_value_r6: assert (link_data == pc_cur + 32'd4 && pc_next == jmp_pc)
        else $error("link write inconsistent");
    if (kind == FLOW_JR)
      p_jr_passthru_r7: assert (pc_next == jr_src && redirect)
        else $error("indirect target altered");
    if (jr_misaligned)
      p_misalign_src_r8: assert (kind == FLOW_JR && pc_next[1:0] != 2'b00)
        else $error("misalignment flag outside indirect jump");
    if ((kind == FLOW_BEQ || kind == FLOW_BNE) && !br_take)
      p_fall_through_r4: assert (!redirect && pc_next == seq_pc)
        else $error("untaken branch redirected");
  end
endmodule

// File: tb/npc_unit_test.sv
module npc_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [31:0] pc_cur, instr, opnd_a, opnd_b, jr_src;
  logic [31:0] pc_next, link_data;
  logic        redirect, link_we, jr_misaligned;
  logic [4:0]  link_reg;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  npc_unit uut (
    .pc_cur(pc_cur), .instr(instr), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .jr_src(jr_src), .pc_next(pc_next), .redirect(redirect),
    .link_we(link_we), .link_reg(link_reg), .link_data(link_data),
    .jr_misaligned(jr_misaligned)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Apply inputs at a rising edge, then compare with an arithmetic model at
  // the falling edge.
  task automatic run(input string req, input logic [31:0] pc,
                     input logic [31:0] ins, input logic [31:0] a,
                     input logic [31:0] b, input logic [31:0] js);
    longint unsigned nxt;
    bit red, lwe, mis;
    int op, fn, off;
    @(posedge clk);
    pc_cur = pc; instr = ins; opnd_a = a; opnd_b = b; jr_src = js;
    op = int'(ins >> 26);
    fn = int'(ins & 32'h3f);
    off = int'(ins & 32'hffff);
    if (off >= 32768) off = off - 65536;
    nxt = (longint'(pc) + 4) % 64'h1_0000_0000;
    red = 0; lwe = 0; mis = 0;
    if ((op == 4 && a == b) || (op == 5 && a != b)) begin
      nxt = (longint'(pc) + 4 + longint'(off) * 4 + 64'h1_0000_0000) % 64'h1_0000_0000;
      red = 1;
    end else if (op == 2 || op == 3) begin
      nxt = (longint'(pc) / 64'h1000_0000) * 64'h1000_0000 +
            longint'(ins % 32'h0400_0000) * 4;
      red = 1;
      lwe = (op == 3);
    end else if (op == 0 && fn == 8) begin
      nxt = longint'(js);
      red = 1;
      mis = (js % 4) != 0;
    end
    @(negedge clk);
    chk(req, "pc_next", pc_next, nxt[31:0]);
    chk(req, "redirect", {31'd0, redirect}, {31'd0, red});
    chk("R6", "link_we", {31'd0, link_we}, {31'd0, lwe});
    chk("R8", "jr_misaligned", {31'd0, jr_misaligned}, {31'd0, mis});
    if (lwe) begin
      chk("R6", "link_reg", {27'd0, link_reg}, 32'd31);
      chk("R6", "link_data", link_data, pc + 32'd4);
    end
  endtask

  function automatic logic [31:0] mk_i(input int op, input int rest);
    return (32'(op) << 26) | (32'(rest) & 32'h03ff_ffff);
  endfunction

  logic [31:0] pcs  [6] = '{32'h0000_0000, 32'h0000_1000, 32'h0040_0020,
                            32'h7fff_fffc, 32'hf000_0010, 32'hffff_fffc};
  logic [15:0] imms [8] = '{16'h0000, 16'h0001, 16'hffff, 16'h7fff,
                            16'h8000, 16'h0010, 16'hfff0, 16'h1234};

  initial begin
    // Initial state: all-zero word is opcode 0 funct 0, straight-line (R1)
    run("R1", 32'h0000_0000, 32'h0000_0000, 32'd0, 32'd0, 32'd0);

    // R2 / R3 / R4: branches across addresses, offsets and operand relations
    for (int p = 0; p < 6; p++)
      for (int k = 0; k < 8; k++) begin
        run("R2", pcs[p], mk_i(4, {10'h155, imms[k]}), 32'h1234_5678, 32'h1234_5678, 32'd0);
        run("R4", pcs[p], mk_i(4, {10'h155, imms[k]}), 32'h1234_5678, 32'h1234_5679, 32'd0);
        run("R3", pcs[p], mk_i(5, {10'h0aa, imms[k]}), 32'h8000_0000, 32'h0000_0000, 32'd0);
        run("R4", pcs[p], mk_i(5, {10'h0aa, imms[k]}), 32'hffff_ffff, 32'hffff_ffff, 32'd0);
      end

    // R5 / R6: region jumps in several regions
    for (int p = 0; p < 6; p++) begin
      run("R5", pcs[p], mk_i(2, 26'h3ff_ffff), 32'd0, 32'd1, 32'd0);
      run("R5", pcs[p], mk_i(2, 26'h000_0001), 32'd0, 32'd1, 32'd0);
      run("R6", pcs[p], mk_i(3, 26'h2a5_5a5a), 32'd0, 32'd1, 32'd0);
      run("R6", pcs[p], mk_i(3, 26'h000_0000), 32'd0, 32'd1, 32'd0);
    end

    // R7 / R8: indirect jump with each low-bit pattern
    for (int lo = 0; lo < 4; lo++) begin
      run("R7", 32'h0000_4000, mk_i(0, 32'h03e0_0008), 32'd0, 32'd0, 32'h8000_1230 | 32'(lo));
      run("R8", 32'hf000_0000, mk_i(0, 32'h0000_0008), 32'd5, 32'd5, 32'h0000_0010 | 32'(lo));
    end

    // R1: every major opcode with equal and unequal operands
    for (int op = 0; op < 64; op++) begin
      run("R1", 32'h0010_0000, mk_i(op, 32'h0123_4567), 32'd7, 32'd7, 32'h0000_0003);
      run("R1", 32'h0010_0000, mk_i(op, 32'h0123_4567), 32'd7, 32'd9, 32'h0000_0003);
    end

    // R1 / R7: every function code under opcode 0
    for (int fn = 0; fn < 64; fn++)
      run(fn == 8 ? "R7" : "R1", 32'h0badf00c, mk_i(0, 32'h0011_2200 | 32'(fn)),
          32'd1, 32'd2, 32'h0000_2222);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule